// File: doc/BRIEF.md
# Multi-lane pixel word serializer

This transmit-side block accepts one video pixel per pixel-clock cycle and sends it over one, two or three serial lanes clocked at the bit rate. A pixel consists of 24 colour bits, an active-low horizontal sync, an active-low vertical sync, an active-high data enable and two auxiliary status bits. The block adds an odd parity bit over the colour, sync and enable bits. This gives a 30-bit word, which is shifted out most significant bit first and dealt round-robin across the active lanes.

The pixel clock and the bit clock are phase-related. For n active lanes the bit clock runs at 30/n times the pixel rate. The pixel bus is captured on each rising edge of the pixel clock into a holding register. At every word boundary the bit-clock side moves the held word into its shift register and samples the lane-count selection. A word-start strobe marks the first bit period of each word, so that a downstream framer can align to it.

Top module: `pixel_lane_serializer`

## Requirements
- R1: While `rst_n` is low, every lane output and `word_start_o` are 0.
- R2: The word is laid out as red in bits 29:22, green in 21:14, blue in 13:6, hsync in 5, vsync in 4, data enable in 3, aux in 2:1 and parity in 0. In bit period k of a word with n active lanes, lane j (j < n) carries word bit 29 - (k*n + j).
- R3: Bit 0 of the word makes the number of ones across the colour, sync, enable and parity bits odd. The aux bits take no part in the parity.
- R4: A `lane_sel_i` of 1, 2 or 3 gives that many lanes, and each word then lasts 30, 15 or 10 bit periods. A value of 0 is treated as one lane. Words follow each other with no idle period between them.
- R5: `lane_sel_i` is sampled only on the bit-clock edge that loads a new word. Changing it in the middle of a word has no effect on that word.
- R6: Lanes at or above the active lane count drive a constant 0.
- R7: `word_start_o` is high during the first bit period of each word and low during every other bit period.
- R8: Each loaded word is the pixel captured on the latest pixel-clock rising edge before the load. Changes on the pixel bus without a pixel-clock edge are not sent. If no new edge occurs, the held pixel is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit-rate clock |
| pix_clk | input | 1 | Pixel clock; its rising edge captures the pixel bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| red_i | input | 8 | Red component |
| grn_i | input | 8 | Green component |
| blu_i | input | 8 | Blue component |
| hsync_n_i | input | 1 | Horizontal sync, active low |
| vsync_n_i | input | 1 | Vertical sync, active low |
| de_i | input | 1 | Data enable, active high |
| aux_i | input | 2 | Auxiliary status bits |
| lane_sel_i | input | 2 | Number of active lanes (0 means 1) |
| lane_o | output | 3 | Serial data, one bit per lane |
| word_start_o | output | 1 | High during the first bit period of each word |

## Verification
The assertions assume that the pixel clock is phase-related to the bit clock. They also assume that its rising edge falls inside a word, so that the holding register is settled before the next load edge. Under these assumptions a lane-count change can only appear at a word start, and the strobe never repeats on consecutive bit periods.

The stimulus drives all inputs on falling edges of the bit clock. It raises the pixel clock only during the last bit period of each word and lowers it in the first bit period of the next word. It sweeps every lane setting, including the out-of-range value 0, across all 32 combinations of the sync, enable and aux bits. A walking one is passed through the colour bits to exercise the parity.

// File: rtl/pixel_lane_serializer.sv
module pixel_lane_serializer #(
  parameter int COLOR_W   = 8,
  parameter int AUX_W     = 2,
  parameter int MAX_LANES = 3,
  localparam int LSEL_W   = $clog2(MAX_LANES + 1)
) (
  input  logic                 bit_clk,
  input  logic                 pix_clk,
  input  logic                 rst_n,
  input  logic [COLOR_W-1:0]   red_i,
  input  logic [COLOR_W-1:0]   grn_i,
  input  logic [COLOR_W-1:0]   blu_i,
  input  logic                 hsync_n_i,
  input  logic                 vsync_n_i,
  input  logic                 de_i,
  input  logic [AUX_W-1:0]     aux_i,
  input  logic [LSEL_W-1:0]    lane_sel_i,
  output logic [MAX_LANES-1:0] lane_o,
  output logic                 word_start_o
);
  // WORD_W must divide evenly by every lane count up to MAX_LANES
  localparam int WORD_W = 3 * COLOR_W + 4 + AUX_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic              par;
  logic [WORD_W-1:0] pix_word, hold_q, sh_q;
  logic [LSEL_W-1:0] sel_n, lanes_q;
  logic [CNT_W-1:0]  cnt_q, per_lane;
  logic              started_q, load;

  assign par      = ~^{red_i, grn_i, blu_i, hsync_n_i, vsync_n_i, de_i};
  assign pix_word = {red_i, grn_i, blu_i, hsync_n_i, vsync_n_i, de_i, aux_i, par};

  always_ff @(posedge pix_clk or negedge rst_n)
    if (!rst_n) hold_q <= '0;
    else        hold_q <= pix_word;

  assign sel_n = (lane_sel_i == '0 || lane_sel_i > LSEL_W'(MAX_LANES)) ? LSEL_W'(1) : lane_sel_i;

  always_comb begin
    per_lane = CNT_W'(WORD_W);
    for (int i = 1; i <= MAX_LANES; i++)
      if (int'(lanes_q) == i) per_lane = CNT_W'(WORD_W / i);
  end

  assign load = !started_q || (cnt_q == per_lane - CNT_W'(1));

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      started_q <= 1'b0;
      cnt_q     <= '0;
      lanes_q   <= LSEL_W'(1);
      sh_q      <= '0;
    end else if (load) begin
      started_q <= 1'b1;
      cnt_q     <= '0;
      lanes_q   <= sel_n;
      sh_q      <= hold_q;
    end else begin
      cnt_q     <= cnt_q + CNT_W'(1);
      sh_q      <= sh_q << lanes_q;
    end

  assign word_start_o = started_q && (cnt_q == '0);

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    assign lane_o[j] = started_q && (LSEL_W'(j) < lanes_q) && sh_q[WORD_W-1-j];
  end
endmodule

module pixel_lane_serializer_chk #(
  parameter int MAX_LANES = 3,
  parameter int LSEL_W    = 2,
  parameter int CNT_W     = 5,
  parameter int WORD_W    = 30
) (
  input logic                 bit_clk,
  input logic                 rst_n,
  input logic                 started_q,
  input logic [CNT_W-1:0]     cnt_q,
  input logic [LSEL_W-1:0]    lanes_q,
  input logic [MAX_LANES-1:0] lane_o,
  input logic                 word_start_o
);
  p_lane_range_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    started_q |-> (lanes_q >= LSEL_W'(1) && int'(lanes_q) <= MAX_LANES));

  p_cnt_bound_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    started_q |-> (int'(cnt_q) * int'(lanes_q) < WORD_W));

  p_sel_hold_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !$stable(lanes_q) |-> word_start_o);

  for (genvar j = 1; j < MAX_LANES; j++) begin : g_idle
    p_idle_zero_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (int'(lanes_q) <= j) |-> !lane_o[j]);
  end

  p_start_gap_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    word_start_o |=> !word_start_o);

  p_first_start_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(started_q) |-> word_start_o);
endmodule

bind pixel_lane_serializer pixel_lane_serializer_chk #(
  .MAX_LANES(MAX_LANES), .LSEL_W(LSEL_W), .CNT_W(CNT_W), .WORD_W(WORD_W)
) chk_i (
  .bit_clk(bit_clk), .rst_n(rst_n), .started_q(started_q), .cnt_q(cnt_q),
  .lanes_q(lanes_q), .lane_o(lane_o), .word_start_o(word_start_o)
);

// File: tb/pixel_lane_serializer_tb.sv
module pixel_lane_serializer_tb_top;
  logic       bit_clk = 1'b0;
  logic       pix_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [7:0] red_i = '0, grn_i = '0, blu_i = '0;
  logic       hsync_n_i = 1'b1, vsync_n_i = 1'b1, de_i = 1'b0;
  logic [1:0] aux_i = '0, lane_sel_i = 2'd1;
  logic [2:0] lane_o;
  logic       word_start_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [29:0] last_w = '0;

  always #4 bit_clk = ~bit_clk;

  pixel_lane_serializer dut_i (
    .bit_clk(bit_clk), .pix_clk(pix_clk), .rst_n(rst_n),
    .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
    .hsync_n_i(hsync_n_i), .vsync_n_i(vsync_n_i), .de_i(de_i), .aux_i(aux_i),
    .lane_sel_i(lane_sel_i), .lane_o(lane_o), .word_start_o(word_start_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge bit_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // Called at a falling edge just before a load edge.
  task automatic send(input logic [23:0] rgb, input logic [4:0] ctl, input logic [1:0] sel,
                      input bit clk_en, input bit use_mid, input logic [1:0] mid);
    int n, len;
    logic [29:0] w, rx;
    logic [2:0] exp_l;
    {red_i, grn_i, blu_i} = rgb;
    {hsync_n_i, vsync_n_i, de_i, aux_i} = ctl;
    lane_sel_i = sel;
    if (clk_en) begin
      w = {rgb, ctl, ~^{rgb, ctl[4:2]}};
      pix_clk = 1'b1;
    end else w = last_w;
    last_w = w;
    n   = (sel == 2'd0) ? 1 : int'(sel);
    len = 30 / n;
    rx  = '0;
    for (int k = 0; k < len; k++) begin
      @(negedge bit_clk);
      if (k == 0) pix_clk = 1'b0;
      if (k == 1 && use_mid) begin
        lane_sel_i = mid;
        {red_i, grn_i, blu_i} = ~rgb;
      end
      chk(k == 0 ? "R7 start strobe" : "R7 strobe low mid-word", 32'(word_start_o), 32'(k == 0));
      for (int j = 0; j < 3; j++) begin
        exp_l[j] = (j < n) ? w[29 - (k * n + j)] : 1'b0;
        if (j < n) rx[29 - (k * n + j)] = lane_o[j];
      end
      if (use_mid) chk("R5 mid-word select change", 32'(lane_o), 32'(exp_l));
      else         chk("R2/R6 lane bits", 32'(lane_o), 32'(exp_l));
    end
    chk(clk_en ? "R2 word reassembled" : "R8 held pixel resent", 32'(rx), 32'(w));
    chk("R3 odd parity", 32'($countones({rx[29:3], rx[0]}) % 2), 32'd1);
  endtask

  initial begin
    repeat (2) @(negedge bit_clk);
    red_i = 8'hFF; pix_clk = 1'b1;
    @(negedge bit_clk);
    chk("R1 lanes in reset", 32'(lane_o), 32'd0);
    chk("R1 strobe in reset", 32'(word_start_o), 32'd0);
    pix_clk = 1'b0;
    @(negedge bit_clk);
    chk("R1 lanes in reset", 32'(lane_o), 32'd0);
    rst_n = 1'b1;
    // R4: every lane setting, including 0, across all control combinations
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 32; c++)
        send(24'(32'h00A5C3 * (c + 3) ^ (s << 20)), 5'(c), 2'(s), 1, 0, 2'd0);
    for (int b = 0; b < 24; b++)
      send(24'(1) << b, 5'(b), 2'd3, 1, 0, 2'd0);
    // R5: mid-word selection changes
    send(24'h13579B, 5'h15, 2'd1, 1, 1, 2'd3);
    send(24'hFEDCBA, 5'h0A, 2'd3, 1, 1, 2'd2);
    send(24'h0F0F0F, 5'h1F, 2'd2, 1, 1, 2'd0);
    send(24'h800001, 5'h04, 2'd3, 1, 1, 2'd1);
    // R8: bus changes without a pixel-clock edge
    send(24'h2468AC, 5'h11, 2'd2, 1, 0, 2'd0);
    send(24'hDEAD00, 5'h0E, 2'd2, 0, 0, 2'd0);
    send(24'h0000BE, 5'h03, 2'd3, 0, 0, 2'd0);
    send(24'h55AA55, 5'h1B, 2'd1, 1, 0, 2'd0);
    @(negedge bit_clk);
    chk("R4 back-to-back start", 32'(word_start_o), 32'd1);
    finish_run();
  end
endmodule